// File: doc/BRIEF.md
# I2C Host Register and FIFO Front End

This block is the software-facing register file of an I2C host peripheral. A simple 32-bit register bus reaches the block through an address, write and read strobes, write data and combinational read data. Behind it sit the command bits, a 10-bit target address, two clock divider values, transmit and receive configuration words, the sticky status and the interrupt line. Two byte FIFOs sit behind a single data port. A bus write to the data port queues a byte for transmission. A bus read of the data port takes the oldest received byte.

The transaction engine that drives the wires is a neighbour block. It sees the command fields, the target address, the dividers, the receive byte count and a one-cycle start strobe. It drains the transmit FIFO with a pop strobe and fills the receive FIFO with a push strobe. It reports completion, target-address no-acknowledge and data no-acknowledge as single-cycle events. Software acknowledges all status at once through one clear bit in the status word.

Top module: `i2c_reg_front`

## Requirements
- R1: After reset every register reads 0, both FIFOs are empty, `irq` is 0 and `startPulse` is 0.
- R2: The command word at offset 0x04 stores bit0 (host enable), bit1 (10-bit address mode), bit3 (interrupt enable), bit4 (read direction) and bit5 (combined write-then-read). It reads these back, and bit2 always reads 0. Bits 0, 1, 4 and 5 drive `cmdMaster`, `cmdTenBit`, `cmdRead` and `cmdCombined`.
- R3: A write of 1 to command bit6 raises `startPulse` for exactly the one cycle after the write. Bit6 reads back as 0 once that cycle has passed.
- R4: Offset 0x10 holds target address bits [6:0] in its bits [6:0]. Offset 0x0C holds address bits [9:7] in its bits [2:0]. Wider write bits are dropped, and `tgtAddr` shows the joined 10-bit value.
- R5: Offsets 0x14 and 0x18 each hold a 16-bit divider that is read back and driven on `divFast` and `divHigh`. Upper write bits are dropped.
- R6: Each bus write to the data port at 0x24 queues `busWdata[7:0]` in the 16-deep transmit FIFO. `txData` shows the oldest byte, and `txPop` removes it. A write to a full FIFO is dropped.
- R7: Each `rxPush` queues `rxData` in the 16-deep receive FIFO, and `rxFull` flags 16 bytes held. A push while full is dropped. A bus read of 0x24 returns the oldest byte in bits [7:0] and removes it. A read while empty returns 0 and changes nothing.
- R8: Writing 1 to bit7 of the transmit config word (0x1C) empties the transmit FIFO. Writing 1 to bit7 of the receive config word (0x20) empties the receive FIFO. Bit7 of both words always reads 0.
- R9: Bits [3:0] of the receive config word hold the receive byte count minus one and drive `rdCount`. Bits [3:0] of the transmit config word are stored and read back.
- R10: Status at 0x28 has bit0 done, bit1 address no-acknowledge and bit2 data no-acknowledge. Each bit is set by its event and holds until software writes 1 to status bit7. An event in the same cycle as that clear write remains set.
- R11: `irq` is 1 exactly when the interrupt enable bit is 1 and any status bit [2:0] is set.
- R12: Offsets outside the map read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Register byte offset |
| busWe | input | 1 | Register write strobe |
| busRe | input | 1 | Register read strobe (pops receive FIFO at 0x24) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for `busAddr` |
| cmdMaster | output | 1 | Host enable |
| cmdTenBit | output | 1 | 10-bit address mode |
| cmdRead | output | 1 | Read direction |
| cmdCombined | output | 1 | Combined write-then-read |
| startPulse | output | 1 | One-cycle start request |
| tgtAddr | output | 10 | Target address |
| divFast | output | 16 | Fast-speed divider |
| divHigh | output | 16 | High-speed divider |
| rdCount | output | 4 | Receive byte count minus one |
| txPop | input | 1 | Engine takes the oldest transmit byte |
| txData | output | 8 | Oldest transmit byte |
| txEmpty | output | 1 | Transmit FIFO empty |
| rxPush | input | 1 | Engine stores a received byte |
| rxData | input | 8 | Received byte |
| rxFull | output | 1 | Receive FIFO full |
| evDone | input | 1 | Transfer finished event |
| evAddrNak | input | 1 | Target address not acknowledged event |
| evDataNak | input | 1 | Data byte not acknowledged event |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: 16-entry FIFOs, 16-bit dividers, an 8-bit offset and a 32-bit data word. At a depth of 16, a run of 17 pushes fills each FIFO and reaches the dropped-write case, which exercises the wrap of both pointers. The same run shows that the FIFO order holds across the wrap. With 16-bit dividers, a 17-bit write shows that high bits are dropped. With a 4-bit count field, the largest read length of 16 bytes fits.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  localparam logic [7:0] OFS_CMD      = 8'h04;
  localparam logic [7:0] OFS_TGT_HI   = 8'h0C;
  localparam logic [7:0] OFS_TGT_LO   = 8'h10;
  localparam logic [7:0] OFS_DIV_FAST = 8'h14;
  localparam logic [7:0] OFS_DIV_HIGH = 8'h18;
  localparam logic [7:0] OFS_TX_CFG   = 8'h1C;
  localparam logic [7:0] OFS_RX_CFG   = 8'h20;
  localparam logic [7:0] OFS_DATA     = 8'h24;
  localparam logic [7:0] OFS_STAT     = 8'h28;

  localparam int BIT_MASTER = 0;
  localparam int BIT_TEN    = 1;
  localparam int BIT_IRQEN  = 3;
  localparam int BIT_READ   = 4;
  localparam int BIT_COMB   = 5;
  localparam int BIT_START  = 6;
  localparam int BIT_FLUSH  = 7;
  localparam int BIT_CLEAR  = 7;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CMD, SEL_TGT_HI, SEL_TGT_LO, SEL_DIV_FAST,
    SEL_DIV_HIGH, SEL_TX_CFG, SEL_RX_CFG, SEL_DATA, SEL_STAT
  } regSel_e;

  typedef struct packed {
    logic    wrCmd;
    logic    wrTgtHi;
    logic    wrTgtLo;
    logic    wrDivFast;
    logic    wrDivHigh;
    logic    wrTxCfg;
    logic    wrRxCfg;
    logic    wrData;
    logic    wrStat;
    logic    rdData;
    regSel_e sel;
  } regStrobe_t;
endpackage

// File: rtl/i2c_byte_fifo.sv
module i2c_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic doPush, doPop;

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full && !flush;
  assign doPop  = pop && !empty && !flush;
  assign head   = mem[rdPtr];

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= stepPtr(wrPtr);
      if (doPop)  rdPtr <= stepPtr(rdPtr);
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> empty);
  p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pop && empty && !push && !flush) |=> empty);
endmodule

// File: rtl/i2c_reg_ctrl.sv
module i2c_reg_ctrl
  import i2c_reg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  output regStrobe_t        strobe
);
  regSel_e sel;

  always_comb begin
    case (busAddr)
      ADDR_W'(OFS_CMD):      sel = SEL_CMD;
      ADDR_W'(OFS_TGT_HI):   sel = SEL_TGT_HI;
      ADDR_W'(OFS_TGT_LO):   sel = SEL_TGT_LO;
      ADDR_W'(OFS_DIV_FAST): sel = SEL_DIV_FAST;
      ADDR_W'(OFS_DIV_HIGH): sel = SEL_DIV_HIGH;
      ADDR_W'(OFS_TX_CFG):   sel = SEL_TX_CFG;
      ADDR_W'(OFS_RX_CFG):   sel = SEL_RX_CFG;
      ADDR_W'(OFS_DATA):     sel = SEL_DATA;
      ADDR_W'(OFS_STAT):     sel = SEL_STAT;
      default:               sel = SEL_NONE;
    endcase
  end

  always_comb begin
    strobe.sel       = sel;
    strobe.wrCmd     = busWe && (sel == SEL_CMD);
    strobe.wrTgtHi   = busWe && (sel == SEL_TGT_HI);
    strobe.wrTgtLo   = busWe && (sel == SEL_TGT_LO);
    strobe.wrDivFast = busWe && (sel == SEL_DIV_FAST);
    strobe.wrDivHigh = busWe && (sel == SEL_DIV_HIGH);
    strobe.wrTxCfg   = busWe && (sel == SEL_TX_CFG);
    strobe.wrRxCfg   = busWe && (sel == SEL_RX_CFG);
    strobe.wrData    = busWe && (sel == SEL_DATA);
    strobe.wrStat    = busWe && (sel == SEL_STAT);
    strobe.rdData    = busRe && (sel == SEL_DATA);
  end

  // R12: at most one register takes a given write
  p_one_target_r12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrCmd, strobe.wrTgtHi, strobe.wrTgtLo, strobe.wrDivFast,
              strobe.wrDivHigh, strobe.wrTxCfg, strobe.wrRxCfg,
              strobe.wrData, strobe.wrStat}));
endmodule

// File: rtl/i2c_reg_dpath.sv
module i2c_reg_dpath
  import i2c_reg_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int DIV_W      = 16,
  parameter int FIFO_DEPTH = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  regStrobe_t                    strobe,
  input  logic [DATA_W-1:0]             busWdata,
  output logic [DATA_W-1:0]             busRdata,
  output logic                          cmdMaster,
  output logic                          cmdTenBit,
  output logic                          cmdRead,
  output logic                          cmdCombined,
  output logic                          startPulse,
  output logic [9:0]                    tgtAddr,
  output logic [DIV_W-1:0]              divFast,
  output logic [DIV_W-1:0]              divHigh,
  output logic [$clog2(FIFO_DEPTH)-1:0] rdCount,
  input  logic                          txPop,
  output logic [7:0]                    txData,
  output logic                          txEmpty,
  input  logic                          rxPush,
  input  logic [7:0]                    rxData,
  output logic                          rxFull,
  input  logic                          evDone,
  input  logic                          evAddrNak,
  input  logic                          evDataNak,
  output logic                          irq
);
  localparam int LVL_W = $clog2(FIFO_DEPTH);

  logic             cmdIrqEn;
  logic [6:0]       tgtLo;
  logic [2:0]       tgtHi;
  logic [LVL_W-1:0] txCfg, rxCfg;
  logic [2:0]       status, events;
  logic [7:0]       rxHead;
  logic             rxEmpty, txFull;
  logic             txFlush, rxFlush, statClear, startReq;
  logic             unusedBits;

  assign unusedBits = ^busWdata[DATA_W-1:DIV_W] ^ txFull;
  assign events     = {evDataNak, evAddrNak, evDone};
  assign txFlush    = strobe.wrTxCfg && busWdata[BIT_FLUSH];
  assign rxFlush    = strobe.wrRxCfg && busWdata[BIT_FLUSH];
  assign statClear  = strobe.wrStat && busWdata[BIT_CLEAR];
  assign startReq   = strobe.wrCmd && busWdata[BIT_START];
  assign tgtAddr    = {tgtHi, tgtLo};
  assign rdCount    = rxCfg;
  assign irq        = cmdIrqEn && (|status);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {cmdMaster, cmdTenBit, cmdIrqEn, cmdRead, cmdCombined, startPulse} <= '0;
      tgtLo   <= '0;
      tgtHi   <= '0;
      divFast <= '0;
      divHigh <= '0;
      txCfg   <= '0;
      rxCfg   <= '0;
      status  <= '0;
    end else begin
      startPulse <= startReq;
      if (strobe.wrCmd) begin
        cmdMaster   <= busWdata[BIT_MASTER];
        cmdTenBit   <= busWdata[BIT_TEN];
        cmdIrqEn    <= busWdata[BIT_IRQEN];
        cmdRead     <= busWdata[BIT_READ];
        cmdCombined <= busWdata[BIT_COMB];
      end
      if (strobe.wrTgtLo)   tgtLo   <= busWdata[6:0];
      if (strobe.wrTgtHi)   tgtHi   <= busWdata[2:0];
      if (strobe.wrDivFast) divFast <= busWdata[DIV_W-1:0];
      if (strobe.wrDivHigh) divHigh <= busWdata[DIV_W-1:0];
      if (strobe.wrTxCfg)   txCfg   <= busWdata[LVL_W-1:0];
      if (strobe.wrRxCfg)   rxCfg   <= busWdata[LVL_W-1:0];
      status <= (statClear ? 3'b000 : status) | events;
    end
  end

  i2c_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) txFifo (
    .clk(clk), .rstN(rstN), .flush(txFlush),
    .push(strobe.wrData), .pushData(busWdata[7:0]),
    .pop(txPop), .head(txData), .full(txFull), .empty(txEmpty));

  i2c_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) rxFifo (
    .clk(clk), .rstN(rstN), .flush(rxFlush),
    .push(rxPush), .pushData(rxData),
    .pop(strobe.rdData), .head(rxHead), .full(rxFull), .empty(rxEmpty));

  always_comb begin
    busRdata = '0;
    case (strobe.sel)
      SEL_CMD: begin
        busRdata[BIT_MASTER] = cmdMaster;
        busRdata[BIT_TEN]    = cmdTenBit;
        busRdata[BIT_IRQEN]  = cmdIrqEn;
        busRdata[BIT_READ]   = cmdRead;
        busRdata[BIT_COMB]   = cmdCombined;
        busRdata[BIT_START]  = startPulse;
      end
      SEL_TGT_HI:   busRdata = DATA_W'(tgtHi);
      SEL_TGT_LO:   busRdata = DATA_W'(tgtLo);
      SEL_DIV_FAST: busRdata = DATA_W'(divFast);
      SEL_DIV_HIGH: busRdata = DATA_W'(divHigh);
      SEL_TX_CFG:   busRdata = DATA_W'(txCfg);
      SEL_RX_CFG:   busRdata = DATA_W'(rxCfg);
      SEL_DATA:     busRdata = rxEmpty ? '0 : DATA_W'(rxHead);
      SEL_STAT:     busRdata = DATA_W'(status);
      default:      busRdata = '0;
    endcase
  end

  p_start_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && !startReq) |=> !startPulse);
  p_status_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (statClear && (events == 3'b000)) |=> (status == 3'b000));
  p_irq_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !statClear && !strobe.wrCmd) |=> irq);
endmodule

// File: rtl/i2c_reg_front.sv
module i2c_reg_front
  import i2c_reg_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int DIV_W      = 16,
  parameter int FIFO_DEPTH = 16,
  localparam int LVL_W     = $clog2(FIFO_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              cmdMaster,
  output logic              cmdTenBit,
  output logic              cmdRead,
  output logic              cmdCombined,
  output logic              startPulse,
  output logic [9:0]        tgtAddr,
  output logic [DIV_W-1:0]  divFast,
  output logic [DIV_W-1:0]  divHigh,
  output logic [LVL_W-1:0]  rdCount,
  input  logic              txPop,
  output logic [7:0]        txData,
  output logic              txEmpty,
  input  logic              rxPush,
  input  logic [7:0]        rxData,
  output logic              rxFull,
  input  logic              evDone,
  input  logic              evAddrNak,
  input  logic              evDataNak,
  output logic              irq
);
  regStrobe_t strobe;

  i2c_reg_ctrl #(.ADDR_W(ADDR_W)) ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busRe(busRe), .strobe(strobe));

  i2c_reg_dpath #(.DATA_W(DATA_W), .DIV_W(DIV_W), .FIFO_DEPTH(FIFO_DEPTH)) dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .busRdata(busRdata), .cmdMaster(cmdMaster), .cmdTenBit(cmdTenBit),
    .cmdRead(cmdRead), .cmdCombined(cmdCombined), .startPulse(startPulse),
    .tgtAddr(tgtAddr), .divFast(divFast), .divHigh(divHigh),
    .rdCount(rdCount), .txPop(txPop), .txData(txData), .txEmpty(txEmpty),
    .rxPush(rxPush), .rxData(rxData), .rxFull(rxFull), .evDone(evDone),
    .evAddrNak(evAddrNak), .evDataNak(evDataNak), .irq(irq));
endmodule

// File: tb/i2c_reg_front_test.sv
`timescale 1ns/1ps
module i2c_reg_front_test;
  logic        clk = 0;
  logic        rstN = 0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 0, busRe = 0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        cmdMaster, cmdTenBit, cmdRead, cmdCombined, startPulse;
  logic [9:0]  tgtAddr;
  logic [15:0] divFast, divHigh;
  logic [3:0]  rdCount;
  logic        txPop = 0, rxPush = 0;
  logic [7:0]  txData, rxData = '0;
  logic        txEmpty, rxFull;
  logic        evDone = 0, evAddrNak = 0, evDataNak = 0;
  logic        irq;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  i2c_reg_front uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWdata(busWdata), .busRdata(busRdata), .cmdMaster(cmdMaster),
    .cmdTenBit(cmdTenBit), .cmdRead(cmdRead), .cmdCombined(cmdCombined),
    .startPulse(startPulse), .tgtAddr(tgtAddr), .divFast(divFast),
    .divHigh(divHigh), .rdCount(rdCount), .txPop(txPop), .txData(txData),
    .txEmpty(txEmpty), .rxPush(rxPush), .rxData(rxData), .rxFull(rxFull),
    .evDone(evDone), .evAddrNak(evAddrNak), .evDataNak(evDataNak), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWe = 1;
    @(negedge clk); busWe = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); busAddr = a; busRe = 1; #2 v = busRdata;
    @(negedge clk); busRe = 0;
  endtask

  task automatic pushRx(input logic [7:0] v);
    @(negedge clk); rxData = v; rxPush = 1;
    @(negedge clk); rxPush = 0;
  endtask

  task automatic testReset;
    logic [31:0] v;
    chk("R1 irq", irq, 0); chk("R1 start", startPulse, 0);
    chk("R1 txEmpty", txEmpty, 1); chk("R1 rxFull", rxFull, 0);
    rd(8'h04, v); chk("R1 cmd", v, 0);
    rd(8'h28, v); chk("R1 status", v, 0);
    rd(8'h14, v); chk("R1 divFast", v, 0);
    rd(8'h24, v); chk("R1 data", v, 0);
  endtask

  task automatic testCmd;
    logic [31:0] v;
    wr(8'h04, 32'h0000_003F);
    rd(8'h04, v); chk("R2 cmd readback", v, 32'h3B);
    chk("R2 fields", {cmdMaster, cmdTenBit, cmdRead, cmdCombined}, 4'b1111);
    wr(8'h04, 32'h0000_0011);
    chk("R2 fields b", {cmdMaster, cmdTenBit, cmdRead, cmdCombined}, 4'b1010);
  endtask

  task automatic testStart;
    logic [31:0] v;
    chk("R3 idle", startPulse, 0);
    wr(8'h04, 32'h0000_0041);
    chk("R3 pulse high", startPulse, 1);
    @(negedge clk); chk("R3 pulse low", startPulse, 0);
    rd(8'h04, v); chk("R3 readback", v, 32'h01);
  endtask

  task automatic testAddr;
    logic [31:0] v;
    wr(8'h10, 32'h0000_00FF);
    wr(8'h0C, 32'h0000_00FD);
    rd(8'h10, v); chk("R4 low", v, 32'h7F);
    rd(8'h0C, v); chk("R4 high", v, 32'h05);
    chk("R4 tgtAddr", tgtAddr, 10'h2FF);
  endtask

  task automatic testDiv;
    logic [31:0] v;
    wr(8'h14, 32'h0001_2345);
    wr(8'h18, 32'h0000_00C7);
    rd(8'h14, v); chk("R5 fast", v, 32'h2345);
    rd(8'h18, v); chk("R5 high", v, 32'hC7);
    chk("R5 outs", {divFast, divHigh}, 32'h2345_00C7);
  endtask

  task automatic testTx;
    for (int i = 0; i < 17; i++) wr(8'h24, 32'hFFFF_FFA0 + i);
    chk("R6 not empty", txEmpty, 0);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      chk("R6 order", txData, 8'hA0 + i);
      txPop = 1;
      @(negedge clk); txPop = 0;
    end
    chk("R6 17th dropped", txEmpty, 1);
  endtask

  task automatic testRx;
    logic [31:0] v;
    for (int i = 0; i < 17; i++) pushRx(8'h30 + i);
    chk("R7 full", rxFull, 1);
    for (int i = 0; i < 16; i++) begin
      rd(8'h24, v); chk("R7 order", v, 32'h30 + i);
    end
    chk("R7 drained", rxFull, 0);
    rd(8'h24, v); chk("R7 empty read", v, 0);
    pushRx(8'h5A);
    rd(8'h24, v); chk("R7 after empty read", v, 32'h5A);
    rd(8'h24, v); chk("R7 empty again", v, 0);
  endtask

  task automatic testFlush;
    logic [31:0] v;
    wr(8'h24, 32'h11); wr(8'h24, 32'h22); wr(8'h24, 32'h33);
    chk("R8 tx loaded", txEmpty, 0);
    wr(8'h1C, 32'h0000_0085);
    chk("R8 tx flushed", txEmpty, 1);
    rd(8'h1C, v); chk("R8 tx cfg bit7 / R9 tx level", v, 32'h05);
    pushRx(8'h44); pushRx(8'h55);
    wr(8'h20, 32'h0000_0083);
    rd(8'h24, v); chk("R8 rx flushed", v, 0);
    rd(8'h20, v); chk("R8 rx cfg bit7", v, 32'h03);
    chk("R9 rdCount", rdCount, 4'd3);
    wr(8'h20, 32'h0000_000F);
    chk("R9 rdCount max", rdCount, 4'd15);
  endtask

  task automatic testStatus;
    logic [31:0] v;
    @(negedge clk); evDone = 1; @(negedge clk); evDone = 0;
    rd(8'h28, v); chk("R10 done", v, 32'h1);
    @(negedge clk); evAddrNak = 1; @(negedge clk); evAddrNak = 0;
    rd(8'h28, v); chk("R10 sticky", v, 32'h3);
    @(negedge clk); evDataNak = 1; @(negedge clk); evDataNak = 0;
    rd(8'h28, v); chk("R10 data nak", v, 32'h7);
    wr(8'h28, 32'h80);
    rd(8'h28, v); chk("R10 clear", v, 0);
    @(negedge clk); busAddr = 8'h28; busWdata = 32'h80; busWe = 1; evAddrNak = 1;
    @(negedge clk); busWe = 0; evAddrNak = 0;
    rd(8'h28, v); chk("R10 event wins clear", v, 32'h2);
    wr(8'h28, 32'h80);
  endtask

  task automatic testIrq;
    wr(8'h04, 32'h01);
    @(negedge clk); evDone = 1; @(negedge clk); evDone = 0;
    chk("R11 masked", irq, 0);
    wr(8'h04, 32'h09);
    chk("R11 enabled", irq, 1);
    wr(8'h28, 32'h80);
    chk("R11 cleared", irq, 0);
  endtask

  task automatic testUnmapped;
    logic [31:0] v;
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, v); chk("R12 unmapped read", v, 0);
    rd(8'h04, v); chk("R12 cmd intact", v, 32'h09);
    rd(8'h14, v); chk("R12 div intact", v, 32'h2345);
    chk("R12 tx intact", txEmpty, 1);
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testCmd();
    testStart();
    testAddr();
    testDiv();
    testTx();
    testRx();
    testFlush();
    testStatus();
    testIrq();
    testUnmapped();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule